// File: doc/BRIEF.md
# Vector Floating-Point Magnitude Min/Max Unit

This execution unit takes one instruction word and two source vectors of up to 128 bits. For every lane it compares the two operands by magnitude, ignoring sign. It returns the larger magnitude for the max operation or the smaller one for the min operation, always as a non-negative value.

Lanes may be 16, 32 or 64 bits wide. A built-in decoder reads the instruction word and picks the lane width, the vector length and the operation. Denormals are never flushed, whatever the global mode. The only exception output is an invalid-operation flag, raised by signaling NaNs in active lanes; no input-denormal indication exists.

A request is accepted with a valid/ready handshake. The result, the destination index and an undefined-instruction indication appear one cycle later and are held until the consumer takes them.

Top module: `fam_unit`

## Requirements
- R1: Each active lane outputs the operand whose magnitude (all bits but the sign) is larger when bit 29 of the instruction is 0 (max), or smaller when bit 29 is 1 (min), with the sign bit cleared.
- R2: Operands of equal magnitude, including +0 and -0, yield that magnitude with a positive sign.
- R3: If either operand of a lane is a NaN, the lane result is a NaN with its sign kept. A signaling NaN is chosen over a quiet one, and the first operand is chosen when both are of the same class. The chosen NaN is quieted by setting the top fraction bit.
- R4: Denormal operands are compared and returned exactly, without flushing, and raise no flag.
- R5: flag_invalid_o is the OR, over active lanes, of "either operand is a signaling NaN".
- R6: An instruction is recognised when bit 31 is 0 and bits [28:24] are 01110, plus one of two lane-width forms. Half precision needs bits [23:21]=110 and bits [15:10]=000111. Single or double precision needs bit 23=1, bit 21=1 and bits [15:10]=110111, where bit 22 set selects double.
- R7: When bit 30 is 0, only the low 64 bits are processed. Upper result bits [127:64] are zero, and upper lanes raise no flag.
- R8: undef_o is set, the result is zero and the flag is clear when the feature enable is low, when the encoding is not recognised, or for double precision with bit 30 clear.
- R9: A request accepted while valid_i and ready_o are high appears with valid_o after exactly one clock edge. While valid_o is high and ready_i is low, the outputs hold and ready_o is low.
- R10: rd_o carries bits [4:0] of the accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| feat_en_i | input | 1 | Feature enable for these instructions |
| valid_i | input | 1 | Request valid |
| ready_o | output | 1 | Unit can accept a request |
| insn_i | input | 32 | Instruction word |
| src_n_i | input | 128 | First source vector |
| src_m_i | input | 128 | Second source vector |
| valid_o | output | 1 | Result valid |
| ready_i | input | 1 | Consumer takes the result |
| res_o | output | 128 | Destination vector |
| rd_o | output | 5 | Destination register index |
| undef_o | output | 1 | Instruction undefined |
| flag_invalid_o | output | 1 | Invalid-operation exception |

## Verification
The bench targets sign handling. A unit that compared signed values would return the positive operand instead of the larger magnitude. A unit that cleared the sign of a NaN would hand back a positive NaN where a negative one is expected. NaN priority is exercised with a quiet first operand against a signaling second one, and with two quiet NaNs; a wrong order returns the other payload, or an unquieted one. Other cases cover a denormal against zero, which a flushing unit would return as zero; a signaling NaN placed only in upper lanes of a 64-bit operation, which a unit that ORs flags over every lane would report; the reserved double/64-bit form; and a stalled consumer, where a unit that lets a second request overwrite its held result would lose data.

// File: rtl/fam_pkg.sv
package fam_pkg;
  typedef enum logic [1:0] {LW_H = 2'd0, LW_S = 2'd1, LW_D = 2'd2} lane_w_e;

  typedef struct packed {
    logic    undef;
    logic    is_min;
    logic    q;
    lane_w_e lw;
    logic [4:0] rd;
  } dec_t;
endpackage

// File: rtl/fam_decoder.sv
module fam_decoder
  import fam_pkg::*;
(
  input  logic [31:0] insn_i,
  input  logic        feat_en_i,
  output dec_t        dec_o
);
  logic base_ok, half_ok, sd_ok, reserved;

  always_comb begin
    base_ok  = !insn_i[31] && (insn_i[28:24] == 5'b01110);
    half_ok  = (insn_i[23:21] == 3'b110) && (insn_i[15:10] == 6'b000111);
    sd_ok    = insn_i[23] && insn_i[21] && (insn_i[15:10] == 6'b110111);
    reserved = sd_ok && insn_i[22] && !insn_i[30];
    dec_o.undef  = !feat_en_i || !base_ok || !(half_ok || sd_ok) || reserved;
    dec_o.is_min = insn_i[29];
    dec_o.q      = insn_i[30];
    dec_o.lw     = half_ok ? LW_H : (insn_i[22] ? LW_D : LW_S);
    dec_o.rd     = insn_i[4:0];
  end
endmodule

// File: rtl/fam_lane.sv
module fam_lane #(
  parameter int EW = 8,
  parameter int FW = 23,
  localparam int W = 1 + EW + FW
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         is_min_i,
  output logic [W-1:0] res_o,
  output logic         inv_o
);
  logic a_nan, b_nan, a_snan, b_snan, a_gt;
  logic [W-1:0] pick;
  logic [W-2:0] mag;

  always_comb begin
    a_nan  = (&a_i[W-2:FW]) && (|a_i[FW-1:0]);
    b_nan  = (&b_i[W-2:FW]) && (|b_i[FW-1:0]);
    a_snan = a_nan && !a_i[FW-1];
    b_snan = b_nan && !b_i[FW-1];
    inv_o  = a_snan || b_snan;
    a_gt   = a_i[W-2:0] > b_i[W-2:0];
    // snan first, then first operand
    if (a_snan)      pick = a_i;
    else if (b_snan) pick = b_i;
    else if (a_nan)  pick = a_i;
    else             pick = b_i;
    mag = (a_gt ^ is_min_i) ? a_i[W-2:0] : b_i[W-2:0];
    if (a_gt == 1'b0 && a_i[W-2:0] == b_i[W-2:0]) mag = a_i[W-2:0];
    if (a_nan || b_nan) begin
      res_o = pick;
      res_o[FW-1] = 1'b1;
    end else begin
      res_o = {1'b0, mag};
    end
  end
endmodule

// File: rtl/fam_unit.sv
module fam_unit
  import fam_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            feat_en_i,
  input  logic            valid_i,
  output logic            ready_o,
  input  logic [31:0]     insn_i,
  input  logic [VLEN-1:0] src_n_i,
  input  logic [VLEN-1:0] src_m_i,
  output logic            valid_o,
  input  logic            ready_i,
  output logic [VLEN-1:0] res_o,
  output logic [4:0]      rd_o,
  output logic            undef_o,
  output logic            flag_invalid_o
);
  localparam int NH = VLEN / 16;
  localparam int NS = VLEN / 32;
  localparam int ND = VLEN / 64;
  localparam int HALF = VLEN / 2;

  dec_t dec;
  logic [VLEN-1:0] res_h, res_s, res_d, res_sel, res_n;
  logic [NH-1:0] inv_h, mask_h;
  logic [NS-1:0] inv_s, mask_s;
  logic [ND-1:0] inv_d, mask_d;
  logic inv_n, accept;

  fam_decoder u_dec (.insn_i(insn_i), .feat_en_i(feat_en_i), .dec_o(dec));

  for (genvar g = 0; g < NH; g++) begin : g_h
    fam_lane #(.EW(5), .FW(10)) u_lane (
      .a_i(src_n_i[g*16 +: 16]), .b_i(src_m_i[g*16 +: 16]),
      .is_min_i(dec.is_min), .res_o(res_h[g*16 +: 16]), .inv_o(inv_h[g]));
  end
  for (genvar g = 0; g < NS; g++) begin : g_s
    fam_lane #(.EW(8), .FW(23)) u_lane (
      .a_i(src_n_i[g*32 +: 32]), .b_i(src_m_i[g*32 +: 32]),
      .is_min_i(dec.is_min), .res_o(res_s[g*32 +: 32]), .inv_o(inv_s[g]));
  end
  for (genvar g = 0; g < ND; g++) begin : g_d
    fam_lane #(.EW(11), .FW(52)) u_lane (
      .a_i(src_n_i[g*64 +: 64]), .b_i(src_m_i[g*64 +: 64]),
      .is_min_i(dec.is_min), .res_o(res_d[g*64 +: 64]), .inv_o(inv_d[g]));
  end

  always_comb begin
    mask_h = dec.q ? '1 : {{(NH-NH/2){1'b0}}, {(NH/2){1'b1}}};
    mask_s = dec.q ? '1 : {{(NS-NS/2){1'b0}}, {(NS/2){1'b1}}};
    mask_d = dec.q ? '1 : {{(ND-ND/2){1'b0}}, {(ND/2){1'b1}}};
    unique case (dec.lw)
      LW_H:    begin res_sel = res_h; inv_n = |(inv_h & mask_h); end
      LW_S:    begin res_sel = res_s; inv_n = |(inv_s & mask_s); end
      default: begin res_sel = res_d; inv_n = |(inv_d & mask_d); end
    endcase
    res_n = res_sel;
    if (!dec.q) res_n[VLEN-1:HALF] = '0;
    if (dec.undef) begin
      res_n = '0;
      inv_n = 1'b0;
    end
  end

  assign ready_o = !valid_o || ready_i;
  assign accept  = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o        <= 1'b0;
      res_o          <= '0;
      rd_o           <= '0;
      undef_o        <= 1'b0;
      flag_invalid_o <= 1'b0;
    end else if (accept) begin
      valid_o        <= 1'b1;
      res_o          <= res_n;
      rd_o           <= dec.rd;
      undef_o        <= dec.undef;
      flag_invalid_o <= inv_n;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fam_unit_chk.sv
module fam_unit_chk #(
  parameter int VLEN = 128
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            feat_en_i,
  input logic            valid_i,
  input logic            ready_o,
  input logic [31:0]     insn_i,
  input logic            valid_o,
  input logic            ready_i,
  input logic [VLEN-1:0] res_o,
  input logic [4:0]      rd_o,
  input logic            undef_o,
  input logic            flag_invalid_o
);
  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(res_o) && $stable(rd_o) && $stable(undef_o)));
  // R9
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> valid_o);
  // R8
  undef_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && undef_o) |-> (res_o == '0 && !flag_invalid_o));
  // R8
  feat_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && !feat_en_i) |=> undef_o);
  // R7
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && !insn_i[30]) |=> (res_o[VLEN-1:VLEN/2] == '0));
  // R10
  rd_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (rd_o == $past(insn_i[4:0])));
endmodule

bind fam_unit fam_unit_chk #(.VLEN(VLEN)) u_chk (.*);

// File: tb/fam_unit_tb.sv
module fam_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, feat_en = 1'b1, valid_i = 1'b0, ready_i = 1'b1;
  logic [31:0] insn = '0;
  logic [127:0] src_n = '0, src_m = '0;
  logic ready_o, valid_o, undef_o, inv_o;
  logic [127:0] res_o;
  logic [4:0] rd_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fam_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .feat_en_i(feat_en), .valid_i(valid_i), .ready_o(ready_o),
    .insn_i(insn), .src_n_i(src_n), .src_m_i(src_m), .valid_o(valid_o), .ready_i(ready_i),
    .res_o(res_o), .rd_o(rd_o), .undef_o(undef_o), .flag_invalid_o(inv_o));

  // p: 0 half, 1 single, 2 double
  function automatic logic [31:0] mk(input logic mn, input logic q, input int p, input logic [4:0] rd);
    if (p == 0) return {1'b0, q, mn, 5'b01110, 3'b110, 5'd2, 6'b000111, 5'd1, rd};
    return {1'b0, q, mn, 5'b01110, 1'b1, (p == 2), 1'b1, 5'd2, 6'b110111, 5'd1, rd};
  endfunction
  function automatic logic [127:0] r16(input logic [15:0] x); return {8{x}}; endfunction
  function automatic logic [127:0] r32(input logic [31:0] x); return {4{x}}; endfunction
  function automatic logic [127:0] r64(input logic [63:0] x); return {2{x}}; endfunction

  typedef struct packed {
    logic feat; logic [31:0] insn; logic [127:0] a, b, res; logic undef, inv;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // R1 R6 half max/min
    '{1'b1, mk(0,1,0,5'd3), r16(16'hC200), r16(16'h3C00), r16(16'h4200), 1'b0, 1'b0},
    '{1'b1, mk(1,1,0,5'd4), r16(16'hC200), r16(16'h3C00), r16(16'h3C00), 1'b0, 1'b0},
    // R1 R6 single
    '{1'b1, mk(0,1,1,5'd5), r32(32'h3F800000), r32(32'hC0000000), r32(32'h40000000), 1'b0, 1'b0},
    '{1'b1, mk(1,1,1,5'd6), r32(32'h3F800000), r32(32'hC0000000), r32(32'h3F800000), 1'b0, 1'b0},
    // R1 R6 double
    '{1'b1, mk(0,1,2,5'd7), r64(64'hBFF0000000000000), r64(64'h4000000000000000), r64(64'h4000000000000000), 1'b0, 1'b0},
    '{1'b1, mk(1,1,2,5'd8), r64(64'hBFF0000000000000), r64(64'h4000000000000000), r64(64'h3FF0000000000000), 1'b0, 1'b0},
    // R2 signed zeros, x vs -x
    '{1'b1, mk(0,1,1,5'd9), r32(32'h80000000), r32(32'h00000000), r32(32'h00000000), 1'b0, 1'b0},
    '{1'b1, mk(1,1,1,5'd10), r32(32'hC0400000), r32(32'h40400000), r32(32'h40400000), 1'b0, 1'b0},
    // R4 denormal kept
    '{1'b1, mk(0,1,1,5'd11), r32(32'h80000001), r32(32'h00000000), r32(32'h00000001), 1'b0, 1'b0},
    // R3 negative qNaN keeps sign
    '{1'b1, mk(0,1,1,5'd12), r32(32'hFFC00000), r32(32'h3F800000), r32(32'hFFC00000), 1'b0, 1'b0},
    // R3 R5 sNaN second beats qNaN first, quieted
    '{1'b1, mk(0,1,1,5'd13), r32(32'h7FC00005), r32(32'hFF800001), r32(32'hFFC00001), 1'b0, 1'b1},
    // R3 two quiet NaNs: first operand
    '{1'b1, mk(1,1,0,5'd14), r16(16'h7E01), r16(16'hFE02), r16(16'h7E01), 1'b0, 1'b0},
    // R3 R5 double sNaN first
    '{1'b1, mk(1,1,2,5'd15), r64(64'h7FF0000000000001), r64(64'h3FF0000000000000), r64(64'h7FF8000000000001), 1'b0, 1'b1},
    // R7 64-bit forms
    '{1'b1, mk(0,0,0,5'd16), r16(16'hC200), r16(16'h3C00), {64'h0, {4{16'h4200}}}, 1'b0, 1'b0},
    '{1'b1, mk(1,0,1,5'd17), r32(32'hC0000000), r32(32'h3F800000), {64'h0, {2{32'h3F800000}}}, 1'b0, 1'b0},
    // R5 R7 sNaN only in upper lanes of 64-bit op
    '{1'b1, mk(0,0,1,5'd18), {32'h7F800001, 32'h7F800001, 32'h3F800000, 32'h3F800000}, 128'h0, {64'h0, {2{32'h3F800000}}}, 1'b0, 1'b0},
    // R8 reserved double 64-bit, feature off
    '{1'b1, mk(0,0,2,5'd19), r64(64'h7FF0000000000001), r64(64'h3FF0000000000000), 128'h0, 1'b1, 1'b0},
    '{1'b0, mk(0,1,0,5'd20), r16(16'hC200), r16(16'h3C00), 128'h0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic f, input logic [31:0] i, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    feat_en = f; insn = i; src_n = a; src_m = b; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset valid", {127'b0, valid_o}, 128'h0);
    chk("R9 reset ready", {127'b0, ready_o}, 128'h1);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      send(VECS[k].feat, VECS[k].insn, VECS[k].a, VECS[k].b);
      chk($sformatf("R9 valid v%0d", k), {127'b0, valid_o}, 128'h1);
      chk($sformatf("R1-res v%0d", k), res_o, VECS[k].res);
      chk($sformatf("R8 undef v%0d", k), {127'b0, undef_o}, {127'b0, VECS[k].undef});
      chk($sformatf("R5 flag v%0d", k), {127'b0, inv_o}, {127'b0, VECS[k].inv});
      chk($sformatf("R10 rd v%0d", k), {123'b0, rd_o}, {123'b0, VECS[k].insn[4:0]});
    end

    // R8 unrecognised encoding
    send(1'b1, 32'h0000_0000, r32(32'h7F800001), 128'h0);
    chk("R8 bad enc undef", {127'b0, undef_o}, 128'h1);
    chk("R8 bad enc res", res_o, 128'h0);

    // R9 backpressure
    @(negedge clk);
    ready_i = 1'b0;
    send(1'b1, mk(0,1,1,5'd21), r32(32'h3F800000), r32(32'h40400000));
    feat_en = 1'b1; insn = mk(1,1,1,5'd22); valid_i = 1'b1;
    chk("R9 ready low", {127'b0, ready_o}, 128'h0);
    repeat (2) @(negedge clk);
    chk("R9 held res", res_o, r32(32'h40400000));
    chk("R9 held rd", {123'b0, rd_o}, 128'd21);
    ready_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R9 second res", res_o, r32(32'h3F800000));
    chk("R9 second rd", {123'b0, rd_o}, 128'd22);
    @(negedge clk);
    chk("R9 drained", {127'b0, valid_o}, 128'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule